// File: doc/BRIEF.md
# Alignment-Aware Load/Store Splitter

This unit sits between a pipeline's load/store stage and a memory port that holds 32-bit words and is addressed by word. It takes one request at a time. Each request carries an access class, a write flag, a size for the generic class, a byte address and up to 64 bits of store data. From these the unit decides whether the alignment is legal for that class.

A legal request becomes one or two aligned word accesses. For a word access at a byte offset other than zero, the unit reads two neighbouring words and rotates the bytes into one 32-bit value. On a store, it splits the data into two masked word writes. A doubleword is always two word accesses. An illegal alignment makes no memory access at all. Instead it returns an exception that carries the faulting byte address.

The memory port is registered. The memory samples a request on the clock edge that ends the cycle in which `mem_req` is high, and it returns read data in the next cycle. Byte order within a word is little-endian: byte address 4k+j lives in bits [8j+7:8j] of word k.

Top module: `ls_unaligned_splitter`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_req` is 0 and `rsp_valid` is 0. Class encoding: 0 word, 1 doubleword, 2 coprocessor, 3 generic. A word-class request at byte offset 0 makes exactly one access.
- R2: A word-class load at byte offset 1, 2 or 3 reads word A and then word A+1, one in each of two consecutive cycles. It returns the four bytes starting at the byte address, little-endian, in `rsp_rdata[31:0]`, with the upper half zero.
- R3: A word-class store at a nonzero offset writes two words, the lower address first. Each write's byte enables cover only the bytes of the four-byte target that fall in that word, so no other byte in memory changes.
- R4: A doubleword request at a word-aligned address makes two word accesses, to A and then A+1. The word at A holds bits [31:0] and the word at A+1 holds bits [63:32], for both load data and store data.
- R5: A doubleword request whose address bits [1:0] are not zero raises an exception.
- R6: A coprocessor request needs address bits [1:0] to be zero, or it raises an exception. When aligned, it makes a single full-word access.
- R7: For the generic class, size 0 (byte) is legal at any address. Size 1 (halfword) needs an even address. Sizes 2 and 3 (word) need a word-aligned address. A generic load returns the data zero-extended.
- R8: An exception response has `rsp_exc`=1 and `rsp_exc_addr` equal to the request's byte address. No `mem_req` is raised for that request.
- R9: `req_ready` is high only when the unit is idle, and `rsp_valid` is a one-cycle pulse. Counting the accepting edge as edge 0, the response appears in cycle 1 for an exception, cycle 3 for a one-access request and cycle 4 for a two-access request.
- R10: Reads always enable all four bytes. Every write enables at least one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this edge |
| req_class | input | 2 | Access class (0 word, 1 doubleword, 2 coprocessor, 3 generic) |
| req_we | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | Generic-class size: 0 byte, 1 half, 2/3 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store data, low bytes first |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data on byte lanes |
| mem_rdata | input | 32 | Read data, one cycle after the access |
| rsp_valid | output | 1 | Response pulse |
| rsp_exc | output | 1 | Address exception |
| rsp_exc_addr | output | ADDR_W | Faulting byte address |
| rsp_rdata | output | 64 | Load result |

## Verification
The in-RTL assertions check several rules on every cycle. No memory access comes next to an exception response. A second access always targets the word after the first. Reads enable every byte and writes enable at least one. `rsp_valid` is a single pulse, and the unit is never ready while it drives the memory. Other behaviour can only be shown through the bench's scenarios, with expected values computed from a byte-level model of memory. These include whether the rotated load bytes are correct, and whether a split store leaves the bytes around it untouched. The same applies to which alignment each class accepts, to the response latency and to the number of accesses per request.

// File: rtl/ls_split_pkg.sv
package ls_split_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [1:0] {
    CLS_WORD   = 2'd0,
    CLS_DWORD  = 2'd1,
    CLS_COPROC = 2'd2,
    CLS_OTHER  = 2'd3
  } op_class_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE0,
    ST_ISSUE1,
    ST_LAST,
    ST_RESP
  } split_state_e;
endpackage

// File: rtl/ls_align_check.sv
module ls_align_check
  import ls_split_pkg::*;
(
  input  op_class_e          cls,
  input  logic [1:0]         size,
  input  logic [1:0]         offset,
  output logic               fault,
  output logic               two_acc,
  output logic [LANES-1:0]   base_mask
);
  always_comb begin
    fault     = 1'b0;
    two_acc   = 1'b0;
    base_mask = '1;
    unique case (cls)
      CLS_WORD:   two_acc = (offset != 2'd0);
      CLS_DWORD: begin
        fault   = (offset != 2'd0);
        two_acc = 1'b1;
      end
      CLS_COPROC: fault = (offset != 2'd0);
      default: begin
        unique case (size)
          2'd0: base_mask = LANES'(1);
          2'd1: begin
            base_mask = LANES'(3);
            fault     = offset[0];
          end
          default: fault = (offset != 2'd0);
        endcase
      end
    endcase
  end
endmodule

// File: rtl/ls_store_lanes.sv
module ls_store_lanes
  import ls_split_pkg::*;
(
  input  logic [2*WORD_W-1:0] wdata,
  input  logic [1:0]          offset,
  input  logic [LANES-1:0]    base_mask,
  input  logic                dword,
  output logic [WORD_W-1:0]   lo_data,
  output logic [WORD_W-1:0]   hi_data,
  output logic [LANES-1:0]    lo_be,
  output logic [LANES-1:0]    hi_be
);
  logic [2*WORD_W-1:0] shifted;
  logic [2*LANES-1:0]  mask2;

  always_comb begin
    shifted = {{WORD_W{1'b0}}, wdata[WORD_W-1:0]} << (8 * offset);
    mask2   = {{LANES{1'b0}}, base_mask} << offset;
    if (dword) begin
      lo_data = wdata[WORD_W-1:0];
      hi_data = wdata[2*WORD_W-1:WORD_W];
      lo_be   = '1;
      hi_be   = '1;
    end else begin
      lo_data = shifted[WORD_W-1:0];
      hi_data = shifted[2*WORD_W-1:WORD_W];
      lo_be   = mask2[LANES-1:0];
      hi_be   = mask2[2*LANES-1:LANES];
    end
  end
endmodule

// File: rtl/ls_load_merge.sv
module ls_load_merge
  import ls_split_pkg::*;
(
  input  op_class_e           cls,
  input  logic [1:0]          size,
  input  logic [1:0]          offset,
  input  logic [WORD_W-1:0]   lo_word,
  input  logic [WORD_W-1:0]   hi_word,
  output logic [2*WORD_W-1:0] result
);
  logic [2*WORD_W-1:0] rot;

  always_comb begin
    rot = {hi_word, lo_word} >> (8 * offset);
    if (cls == CLS_DWORD) begin
      result = {hi_word, lo_word};
    end else if (cls == CLS_OTHER && size == 2'd0) begin
      result = {{(2*WORD_W-8){1'b0}}, rot[7:0]};
    end else if (cls == CLS_OTHER && size == 2'd1) begin
      result = {{(2*WORD_W-16){1'b0}}, rot[15:0]};
    end else begin
      result = {{WORD_W{1'b0}}, rot[WORD_W-1:0]};
    end
  end
endmodule

// File: rtl/ls_unaligned_splitter.sv
module ls_unaligned_splitter
  import ls_split_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_class,
  input  logic                req_we,
  input  logic [1:0]          req_size,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [63:0]         req_wdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-3:0]   mem_addr,
  output logic [3:0]          mem_be,
  output logic [31:0]         mem_wdata,
  input  logic [31:0]         mem_rdata,
  output logic                rsp_valid,
  output logic                rsp_exc,
  output logic [ADDR_W-1:0]   rsp_exc_addr,
  output logic [63:0]         rsp_rdata
);
  localparam int WA_W = ADDR_W - 2;

  split_state_e        st;
  op_class_e           cls_in, cls_q;
  logic                we_q, two_q;
  logic [1:0]          size_q, off_q;
  logic [WORD_W-1:0]   w0_q, hi_data_q;
  logic [LANES-1:0]    hi_be_q;

  logic                fault, two_acc;
  logic [LANES-1:0]    base_mask, lo_be, hi_be;
  logic [WORD_W-1:0]   lo_data, hi_data;
  logic [WORD_W-1:0]   merge_lo;
  logic [2*WORD_W-1:0] merged;

  assign cls_in    = op_class_e'(req_class);
  assign req_ready = (st == ST_IDLE);

  ls_align_check u_chk (
    .cls(cls_in), .size(req_size), .offset(req_addr[1:0]),
    .fault(fault), .two_acc(two_acc), .base_mask(base_mask)
  );

  ls_store_lanes u_lanes (
    .wdata(req_wdata), .offset(req_addr[1:0]), .base_mask(base_mask),
    .dword(cls_in == CLS_DWORD),
    .lo_data(lo_data), .hi_data(hi_data), .lo_be(lo_be), .hi_be(hi_be)
  );

  assign merge_lo = two_q ? w0_q : mem_rdata;

  ls_load_merge u_merge (
    .cls(cls_q), .size(size_q), .offset(off_q),
    .lo_word(merge_lo), .hi_word(mem_rdata), .result(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      cls_q        <= CLS_WORD;
      we_q         <= 1'b0;
      two_q        <= 1'b0;
      size_q       <= '0;
      off_q        <= '0;
      w0_q         <= '0;
      hi_data_q    <= '0;
      hi_be_q      <= '0;
      mem_req      <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_be       <= '0;
      mem_wdata    <= '0;
      rsp_valid    <= 1'b0;
      rsp_exc      <= 1'b0;
      rsp_exc_addr <= '0;
      rsp_rdata    <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          rsp_valid <= 1'b0;
          if (req_valid) begin
            cls_q     <= cls_in;
            we_q      <= req_we;
            two_q     <= two_acc;
            size_q    <= req_size;
            off_q     <= req_addr[1:0];
            hi_data_q <= hi_data;
            hi_be_q   <= hi_be;
            if (fault) begin
              st           <= ST_RESP;
              rsp_valid    <= 1'b1;
              rsp_exc      <= 1'b1;
              rsp_exc_addr <= req_addr;
              rsp_rdata    <= '0;
            end else begin
              st        <= ST_ISSUE0;
              mem_req   <= 1'b1;
              mem_we    <= req_we;
              mem_addr  <= req_addr[ADDR_W-1:2];
              mem_be    <= req_we ? lo_be : {LANES{1'b1}};
              mem_wdata <= lo_data;
            end
          end
        end
        ST_ISSUE0: begin
          if (two_q) begin
            st        <= ST_ISSUE1;
            mem_addr  <= mem_addr + WA_W'(1);
            mem_be    <= we_q ? hi_be_q : {LANES{1'b1}};
            mem_wdata <= hi_data_q;
          end else begin
            st      <= ST_LAST;
            mem_req <= 1'b0;
          end
        end
        ST_ISSUE1: begin
          st      <= ST_LAST;
          mem_req <= 1'b0;
          w0_q    <= mem_rdata;
        end
        ST_LAST: begin
          st           <= ST_RESP;
          rsp_valid    <= 1'b1;
          rsp_exc      <= 1'b0;
          rsp_exc_addr <= '0;
          rsp_rdata    <= we_q ? '0 : merged;
        end
        default: begin
          st        <= ST_IDLE;
          rsp_valid <= 1'b0;
        end
      endcase
    end
  end

  // R8
  exc_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_exc) |-> (!mem_req && !$past(mem_req)));

  // R2
  second_word_next_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req) && !$past(rst)) |-> (mem_addr == $past(mem_addr) + WA_W'(1)));

  // R10
  read_full_be_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (mem_be == 4'hF));

  // R10
  write_some_be_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_be != 4'h0));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req || rsp_valid) |-> !req_ready);
endmodule

// File: tb/ls_unaligned_splitter_test.sv
module ls_unaligned_splitter_test;
  localparam int AW = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_class = '0;
  logic        req_we = 1'b0;
  logic [1:0]  req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        mem_req, mem_we;
  logic [AW-3:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_exc;
  logic [AW-1:0] rsp_exc_addr;
  logic [63:0] rsp_rdata;

  int total = 0;
  int bad = 0;
  int acc_total = 0;
  int cyc = 0;

  logic [31:0] mem [64];
  logic [7:0]  refm [256];

  always #10 clk = ~clk;

  ls_unaligned_splitter #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_class(req_class), .req_we(req_we), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_exc(rsp_exc), .rsp_exc_addr(rsp_exc_addr), .rsp_rdata(rsp_rdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) begin
      acc_total <= acc_total + 1;
      mem_rdata <= mem[mem_addr[5:0]];
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[5:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_fault(input int c, input int sz, input int a);
    case (c)
      0: return 1'b0;
      1, 2: return (a % 4) != 0;
      default: return (sz == 0) ? 1'b0 : (sz == 1) ? ((a % 2) != 0) : ((a % 4) != 0);
    endcase
  endfunction

  function automatic int exp_bytes(input int c, input int sz);
    if (c == 1) return 8;
    if (c == 3 && sz == 0) return 1;
    if (c == 3 && sz == 1) return 2;
    return 4;
  endfunction

  function automatic int exp_accs(input int c, input int sz, input int a);
    if (exp_fault(c, sz, a)) return 0;
    if (c == 1) return 2;
    if (c == 0 && (a % 4) != 0) return 2;
    return 1;
  endfunction

  function automatic logic [63:0] ref_load(input int a, input int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v[8*i +: 8] = refm[(a + i) % 256];
    return v;
  endfunction

  task automatic do_op(input int c, input bit we, input int sz, input int a, input logic [63:0] wd);
    string tag;
    int lat, acc0, n, ea, ee;
    bit f;
    logic [63:0] ed;
    int mism;
    f  = exp_fault(c, sz, a);
    n  = exp_bytes(c, sz);
    ea = exp_accs(c, sz, a);
    if (f) tag = (c == 1) ? "R5 R8" : (c == 2) ? "R6 R8" : "R7 R8";
    else if (c == 0) tag = ((a % 4) == 0) ? "R1" : (we ? "R3" : "R2");
    else if (c == 1) tag = "R4";
    else if (c == 2) tag = "R6";
    else tag = "R7";
    @(negedge clk);
    acc0 = acc_total;
    req_valid = 1'b1; req_class = 2'(c); req_we = we; req_size = 2'(sz);
    req_addr = AW'(a); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    ee = f ? 1 : (ea == 2 ? 4 : 3);
    chk({tag, " R9 latency"}, 64'(lat), 64'(ee));
    chk({tag, " exc flag"}, 64'(rsp_exc), 64'(f));
    chk({tag, " access count"}, 64'(acc_total - acc0), 64'(ea));
    if (f) begin
      chk("R8 exc addr", 64'(rsp_exc_addr), 64'(a));
    end else if (!we) begin
      ed = ref_load(a, n);
      chk({tag, " load data"}, rsp_rdata, ed);
    end else begin
      for (int i = 0; i < n; i++) refm[(a + i) % 256] = wd[8*i +: 8];
      mism = 0;
      for (int w = 0; w < 64; w++)
        for (int b = 0; b < 4; b++)
          if (mem[w][8*b +: 8] !== refm[4*w + b]) mism++;
      chk({tag, " memory bytes"}, 64'(mism), 64'd0);
    end
  endtask

  initial begin
    int c, sz, a;
    void'($urandom(32'd1234));
    for (int w = 0; w < 64; w++) begin
      mem[w] = $urandom;
      for (int b = 0; b < 4; b++) refm[4*w + b] = mem[w][8*b +: 8];
    end
    repeat (3) @(negedge clk);
    chk("R1 reset ready", 64'(req_ready), 64'd1);
    chk("R1 reset mem_req", 64'(mem_req), 64'd0);
    chk("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
    rst = 1'b0;
    // directed word loads and stores at every offset
    for (int o = 0; o < 4; o++) do_op(0, 1'b0, 0, 16 + o, 64'd0);
    for (int o = 0; o < 4; o++) do_op(0, 1'b1, 0, 40 + o, 64'h0000_0000_A1B2_C3D4);
    for (int o = 0; o < 4; o++) do_op(0, 1'b0, 0, 40 + o, 64'd0);
    do_op(0, 1'b0, 0, 255, 64'd0);
    do_op(1, 1'b1, 0, 64, 64'h1122_3344_5566_7788);
    do_op(1, 1'b0, 0, 64, 64'd0);
    do_op(1, 1'b0, 0, 66, 64'd0);
    do_op(2, 1'b0, 0, 8, 64'd0);
    do_op(2, 1'b1, 0, 9, 64'hDEAD_BEEF);
    do_op(3, 1'b0, 1, 21, 64'd0);
    do_op(3, 1'b1, 1, 22, 64'hCAFE);
    do_op(3, 1'b1, 0, 23, 64'h5A);
    do_op(3, 1'b0, 2, 26, 64'd0);
    for (int k = 0; k < 400; k++) begin
      c  = int'($urandom_range(3, 0));
      sz = int'($urandom_range(3, 0));
      a  = int'($urandom_range(255, 0));
      do_op(c, 1'($urandom), sz, a, {$urandom, $urandom});
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule